// File: doc/BRIEF.md
# Path-Planner Run Sequencer

This block is the top-level controller of a grid path planner. It holds the planner idle with `readyOut` high until a solve request comes in. It then brings the working grid to a known state. To do that it reads every cell of a preserved master map from a source RAM and writes each cell into the working grid RAM, with the visited and direction metadata of that cell cleared.

After the copy it starts the search engine with a one-cycle pulse and waits for that engine's completion. It then starts the path backtracker the same way, waits again and returns to idle. Both engines sit outside this block; it only exchanges start and done strobes with them. Because the master map is never written, every solve runs on a fresh grid, so a search can be repeated as often as needed.

Top module: `plan_sequencer`

## Requirements
- R1: After reset `readyOut` is 1, and `searchStart`, `traceStart`, `srcRdEn` and `wrkWrEn` are all 0.
- R2: A `solveIn` sampled high at a clock edge while `readyOut` is 1 is accepted. From the next cycle `readyOut` is 0, and it stays 0 until the run ends.
- R3: The copy asserts `srcRdEn` for exactly CELLS = MAP_W*MAP_H consecutive cycles, starting in the cycle after acceptance. `srcAddr` runs 0, 1, … CELLS-1, one address per cycle, and the source RAM returns data one cycle after each read.
- R4: Each source word is written to the same working address one cycle after its read, for exactly CELLS writes in ascending address order. The write word has the source cell in bits [CELL_W-1:0] and zeros in the META_W upper bits (visited and direction).
- R5: `searchStart` is a single-cycle pulse that appears CELLS+1 cycles after the accepting edge, once per run.
- R6: `searchDone` is taken only after `searchStart` has been issued. `traceStart` is a single-cycle pulse in the cycle after the edge that samples `searchDone`.
- R7: `traceDone`, taken only after `traceStart`, returns the sequencer to idle, and `readyOut` is 1 in the cycle after the edge that samples it.
- R8: A `solveIn` pulse while `readyOut` is 0 is ignored. It causes no further source reads or working writes, and no extra start pulse.
- R9: A done strobe that arrives outside its own phase is ignored. This covers `searchDone` during the copy and `traceDone` during the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| solveIn | input | 1 | Solve request |
| readyOut | output | 1 | Idle, ready for a solve |
| searchStart | output | 1 | Start pulse to the search engine |
| searchDone | input | 1 | Search engine finished |
| traceStart | output | 1 | Start pulse to the path backtracker |
| traceDone | input | 1 | Path backtracker finished |
| srcRdEn | output | 1 | Master map read enable |
| srcAddr | output | ADDR_W | Master map read address |
| srcRdData | input | CELL_W | Master map read data (one-cycle latency) |
| wrkWrEn | output | 1 | Working grid write enable |
| wrkAddr | output | ADDR_W | Working grid write address |
| wrkWrData | output | CELL_W+META_W | Working grid write word |

## Verification
Runs are driven with several master-map patterns, so a dropped, shifted or stale data word shows up as a mismatch at the wrong address. The working grid is pre-filled with all-ones, so metadata bits that are not cleared are visible. Runs also vary the search and trace latencies, which separates correct waiting on a done strobe from advancing on a fixed count. Other runs add stray solve requests and out-of-phase done strobes, which separate ignored inputs from inputs that restart or shortcut the sequence.

// File: rtl/plan_seq_pkg.sv
package plan_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_INIT   = 2'd1,
    ST_SEARCH = 2'd2,
    ST_TRACE  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic copyGo;   // restart the map copy from address zero
  } seqStrobe_t;
endpackage

// File: rtl/plan_seq_ctrl.sv
module plan_seq_ctrl
  import plan_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       solveIn,
  input  logic       copyDone,
  input  logic       searchDone,
  input  logic       traceDone,
  output logic       readyOut,
  output logic       searchStart,
  output logic       traceStart,
  output seqStrobe_t strb
);
  seqState_t state, stateNext;
  logic      launched;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (solveIn) stateNext = ST_INIT;
      ST_INIT:   if (copyDone) stateNext = ST_SEARCH;
      ST_SEARCH: if (launched && searchDone) stateNext = ST_TRACE;
      ST_TRACE:  if (launched && traceDone) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      launched <= 1'b0;
    end else begin
      state    <= stateNext;
      launched <= (stateNext == state) &&
                  ((state == ST_SEARCH) || (state == ST_TRACE));
    end
  end

  assign readyOut    = (state == ST_IDLE);
  assign searchStart = (state == ST_SEARCH) && !launched;
  assign traceStart  = (state == ST_TRACE) && !launched;
  assign strb.copyGo = (state == ST_IDLE) && solveIn;

  // R5: the search start pulse lasts one cycle and follows the last copy write
  a_r5_search_pulse: assert property (@(posedge clk) disable iff (!rstN)
    searchStart |=> !searchStart);
  a_r5_after_copy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(searchStart) |-> $past(copyDone));
  // R6: the trace start is caused by a sampled search completion
  a_r6_trace_after_search: assert property (@(posedge clk) disable iff (!rstN)
    $rose(traceStart) |-> $past(searchDone));
  // R7: ready comes back only after the backtracker reports done
  a_r7_ready_on_trace_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyOut) |-> $past(traceDone));
  // R2: the two start pulses never coincide
  a_r2_single_phase: assert property (@(posedge clk) disable iff (!rstN)
    $countones({searchStart, traceStart, readyOut}) <= 1);
endmodule

// File: rtl/plan_seq_copy.sv
module plan_seq_copy
  import plan_seq_pkg::*;
#(
  parameter int CELLS  = 12,
  parameter int CELL_W = 2,
  parameter int META_W = 3,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobe_t               strb,
  input  logic [CELL_W-1:0]        srcRdData,
  output logic                     srcRdEn,
  output logic [ADDR_W-1:0]        srcAddr,
  output logic                     wrkWrEn,
  output logic [ADDR_W-1:0]        wrkAddr,
  output logic [CELL_W+META_W-1:0] wrkWrData,
  output logic                     copyDone
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(CELLS - 1);

  logic              rdActive, wrValid;
  logic [ADDR_W-1:0] rdAddr, wrAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdActive <= 1'b0;
      rdAddr   <= '0;
      wrValid  <= 1'b0;
      wrAddr   <= '0;
    end else begin
      if (strb.copyGo) begin
        rdActive <= 1'b1;
        rdAddr   <= '0;
      end else if (rdActive) begin
        rdAddr <= rdAddr + 1'b1;
        if (rdAddr == LAST_ADDR) rdActive <= 1'b0;
      end
      wrValid <= rdActive;
      wrAddr  <= rdAddr;
    end
  end

  assign srcRdEn   = rdActive;
  assign srcAddr   = rdAddr;
  assign wrkWrEn   = wrValid;
  assign wrkAddr   = wrAddr;
  assign wrkWrData = {{META_W{1'b0}}, srcRdData};
  assign copyDone  = wrValid && (wrAddr == LAST_ADDR);

  // R8: a new copy is never launched while one is in flight
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    strb.copyGo |-> !rdActive && !wrValid);
  // R4: consecutive writes step the address by one
  a_r4_write_order: assert property (@(posedge clk) disable iff (!rstN)
    wrkWrEn && $past(wrkWrEn) |-> wrkAddr == $past(wrkAddr) + 1'b1);
  // R3: the copy starts at address zero
  a_r3_start_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(srcRdEn) |-> srcAddr == '0);
  // R4: each write follows a read of the same address
  a_r4_write_follows_read: assert property (@(posedge clk) disable iff (!rstN)
    wrkWrEn |-> $past(srcRdEn) && wrkAddr == $past(srcAddr));
endmodule

// File: rtl/plan_sequencer.sv
module plan_sequencer
  import plan_seq_pkg::*;
#(
  parameter int MAP_W  = 4,
  parameter int MAP_H  = 3,
  parameter int CELL_W = 2,
  parameter int META_W = 3,
  localparam int CELLS  = MAP_W * MAP_H,
  localparam int ADDR_W = (CELLS > 1) ? $clog2(CELLS) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     solveIn,
  output logic                     readyOut,
  output logic                     searchStart,
  input  logic                     searchDone,
  output logic                     traceStart,
  input  logic                     traceDone,
  output logic                     srcRdEn,
  output logic [ADDR_W-1:0]        srcAddr,
  input  logic [CELL_W-1:0]        srcRdData,
  output logic                     wrkWrEn,
  output logic [ADDR_W-1:0]        wrkAddr,
  output logic [CELL_W+META_W-1:0] wrkWrData
);
  seqStrobe_t strb;
  logic       copyDone;

  plan_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .solveIn(solveIn), .copyDone(copyDone),
    .searchDone(searchDone), .traceDone(traceDone), .readyOut(readyOut),
    .searchStart(searchStart), .traceStart(traceStart), .strb(strb)
  );

  plan_seq_copy #(
    .CELLS(CELLS), .CELL_W(CELL_W), .META_W(META_W), .ADDR_W(ADDR_W)
  ) copy_i (
    .clk(clk), .rstN(rstN), .strb(strb), .srcRdData(srcRdData),
    .srcRdEn(srcRdEn), .srcAddr(srcAddr), .wrkWrEn(wrkWrEn),
    .wrkAddr(wrkAddr), .wrkWrData(wrkWrData), .copyDone(copyDone)
  );
endmodule

// File: tb/plan_sequencer_tb.sv
`timescale 1ns/100ps
module plan_sequencer_tb_top;
  localparam int MAP_W = 4, MAP_H = 3, CELL_W = 2, META_W = 3;
  localparam int N = MAP_W * MAP_H;
  localparam int AW = $clog2(N);
  localparam int WW = CELL_W + META_W;
  localparam int NRUN = 4;
  // per run: map seed, search latency, trace latency, flags
  // flag bit0: stray solve during trace (R8); bit1: out-of-phase done strobes (R9)
  localparam int SEED [NRUN] = '{1, 3, 2, 7};
  localparam int SLAT [NRUN] = '{0, 5, 2, 9};
  localparam int TLAT [NRUN] = '{0, 3, 7, 1};
  localparam int FLAG [NRUN] = '{0, 1, 2, 3};

  logic clk = 1'b0, rstN = 1'b0;
  logic solveIn = 1'b0, searchDone = 1'b0, traceDone = 1'b0;
  logic readyOut, searchStart, traceStart, srcRdEn, wrkWrEn;
  logic [AW-1:0] srcAddr, wrkAddr;
  logic [CELL_W-1:0] srcRdData;
  logic [WW-1:0] wrkWrData;

  logic [CELL_W-1:0] srcMem [N];
  logic [WW-1:0]     work [N];
  int cyc = 0, checks = 0, errors = 0;
  int rdCount = 0, wrCount = 0, orderErr = 0, searchPulses = 0, tracePulses = 0;
  int searchCyc = 0, traceCyc = 0;

  always #2.5 clk = ~clk;

  plan_sequencer #(.MAP_W(MAP_W), .MAP_H(MAP_H), .CELL_W(CELL_W), .META_W(META_W)) dut_i (
    .clk(clk), .rstN(rstN), .solveIn(solveIn), .readyOut(readyOut),
    .searchStart(searchStart), .searchDone(searchDone), .traceStart(traceStart),
    .traceDone(traceDone), .srcRdEn(srcRdEn), .srcAddr(srcAddr), .srcRdData(srcRdData),
    .wrkWrEn(wrkWrEn), .wrkAddr(wrkAddr), .wrkWrData(wrkWrData)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (srcRdEn) srcRdData <= srcMem[srcAddr];
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (srcRdEn) begin
        if (int'(srcAddr) != rdCount) orderErr++;
        rdCount++;
      end
      if (wrkWrEn) begin
        if (int'(wrkAddr) != wrCount) orderErr++;
        work[wrkAddr] = wrkWrData;
        wrCount++;
      end
      if (searchStart) begin searchPulses++; searchCyc = cyc; end
      if (traceStart) begin tracePulses++; traceCyc = cyc; end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic runPlan(input int r);
    int c0, dn;
    for (int i = 0; i < N; i++) begin
      srcMem[i] = CELL_W'(i * SEED[r] + (SEED[r] >> 1));
      work[i] = '1;
    end
    rdCount = 0; wrCount = 0; orderErr = 0; searchPulses = 0; tracePulses = 0;
    solveIn = 1'b1;
    step();
    solveIn = 1'b0;
    c0 = cyc;
    check("R2 ready low after accept", readyOut, 0);
    if (FLAG[r][1]) begin searchDone = 1'b1; step(); searchDone = 1'b0; end
    while (searchPulses == 0) step();
    check("R5 search start delay", searchCyc - c0, N + 1);
    check("R3 read count", rdCount, N);
    check("R4 write count", wrCount, N);
    check("R3/R4 address order errors", orderErr, 0);
    for (int i = 0; i < N; i++)
      check("R4 working word", int'(work[i]), int'(srcMem[i]));
    check("R9 no trace before search", tracePulses, 0);
    step();
    check("R5 single search pulse", int'(searchStart), 0);
    if (FLAG[r][1]) begin traceDone = 1'b1; step(); traceDone = 1'b0; end
    repeat (SLAT[r]) step();
    check("R9 trace done ignored in search", tracePulses, 0);
    check("R2 ready stays low", readyOut, 0);
    searchDone = 1'b1;
    step();
    searchDone = 1'b0;
    dn = cyc;
    check("R6 trace start timing", traceCyc, dn);
    check("R6 trace start asserted", int'(traceStart), 1);
    step();
    check("R6 single trace pulse", int'(traceStart), 0);
    if (FLAG[r][0]) begin solveIn = 1'b1; step(); solveIn = 1'b0; end
    repeat (TLAT[r]) step();
    check("R2 ready low in trace", readyOut, 0);
    traceDone = 1'b1;
    step();
    traceDone = 1'b0;
    check("R7 ready after trace done", readyOut, 1);
    repeat (3) step();
    check("R8 no extra reads", rdCount, N);
    check("R8 no extra writes", wrCount, N);
    check("R8 no extra search start", searchPulses, 1);
    check("R7 ready held", readyOut, 1);
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    check("R1 ready after reset", readyOut, 1);
    check("R1 search start idle", int'(searchStart), 0);
    check("R1 trace start idle", int'(traceStart), 0);
    check("R1 read idle", int'(srcRdEn), 0);
    check("R1 write idle", int'(wrkWrEn), 0);
    for (int r = 0; r < NRUN; r++) runPlan(r);
    // R9: done strobes while idle start nothing
    searchDone = 1'b1; traceDone = 1'b1;
    step();
    searchDone = 1'b0; traceDone = 1'b0;
    step();
    check("R9 idle ignores done strobes", readyOut, 1);
    check("R9 idle no reads", int'(srcRdEn), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule